// File: doc/BRIEF.md
# Lazy-ECC Line Controller

This controller sits in front of an array of 64-bit memory lines. Each line holds its data word, an 8-bit SECDED check field (Hamming code plus an overall parity bit), one parity bit per byte, and a flag that tells whether the check field matches the data.

A write that enables all bytes stores fresh check bits and sets the flag. A write that enables only some bytes changes those bytes and their parity bits and clears the flag. It never reads the old line, so it costs no read-modify-write. Reads use the full SECDED check while the flag is set and fall back to byte parity while it is clear. A clean whole-line read of a line with its flag clear rebuilds the check field. A scrubber uses idle cycles to walk the array and rebuild the check field of every line whose flag is clear.

The request port uses valid/ready handshaking and allows one operation in flight. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold every `req_*` field stable until that edge. A write completes on its accepting edge, and `req_ready` stays high. A read drops `req_ready` for two cycles and then returns a one-cycle response. The response port cannot be stalled.

Top module: `lazy_ecc_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. Every line reads back as zero, with `rsp_full_check` = 1 and no error output set.
- R2: A write with all mask bits set stores the data and sets the line flag. A later read returns that data with `rsp_full_check` = 1 and no error output.
- R3: A write with a nonzero, partial mask changes only the bytes whose mask bit is set (mask bit i covers data bits 8i+7..8i). It keeps `req_ready` high and clears the line flag, so a later non-repairing read reports `rsp_full_check` = 0.
- R4: A write with an all-zero mask changes neither the data nor the flag of the line.
- R5: `fault_flip` is XORed into the bytes being stored after their check and parity bits are formed. With the flag set, a single flipped data bit is returned corrected, with `rsp_corrected` = 1 and `rsp_uncorrectable` = 0.
- R6: With the flag set, two flipped data bits give `rsp_uncorrectable` = 1 and `rsp_corrected` = 0.
- R7: With the flag clear, a byte parity mismatch gives `rsp_parity_err` = 1. The raw stored data is returned, and `rsp_corrected`, `rsp_uncorrectable` and `rsp_full_check` are all 0.
- R8: A read with all mask bits set, of a line whose flag is clear and whose parity is clean, rebuilds the check field and sets the flag, so the next read of that line reports `rsp_full_check` = 1.
- R9: A read that shows a parity error, or whose mask is not all ones, leaves the line flag unchanged.
- R10: The scrubber acts only in cycles with no pending request while the controller is idle. Its pointer holds in all other cycles and wraps from the last line to line 0. After LINES+1 idle cycles every line has its flag set again.
- R11: The response of a read accepted on edge n appears after edge n+2. `req_ready` is 0 after edges n and n+1 and 1 after edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | $clog2(LINES) | Line index |
| req_mask | input | 8 | Byte enables; all ones marks a whole-line access |
| req_wdata | input | 64 | Write data |
| fault_flip | input | 64 | Bit flips applied to stored write data (fault injection) |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | 64 | Read data, corrected when possible |
| rsp_full_check | output | 1 | Response was checked with full SECDED |
| rsp_corrected | output | 1 | A single-bit error was corrected |
| rsp_uncorrectable | output | 1 | A double-bit error was detected |
| rsp_parity_err | output | 1 | A byte parity mismatch was found in parity mode |

## Verification
The assertions assume that `req_valid` is never unknown after reset and that the request fields stay stable until they are accepted. The bench drives every input on the falling edge, so each request is seen whole at the next rising edge. They also assume faults enter only through `fault_flip` on writes. The bench therefore flips at most two data bits per line and never touches the check bits. Tests that depend on a clear flag chain their requests with no idle cycle in between, so the scrubber cannot interfere. Scrubbing is tested only by explicit runs of idle cycles.

// File: rtl/lecc_pkg.sv
package lecc_pkg;
  localparam int DATA_W  = 64;
  localparam int BYTES   = DATA_W / 8;
  // smallest r with 2**r >= DATA_W + r + 1
  localparam int HAM_W   = 7;
  localparam int CHK_W   = HAM_W + 1;
  localparam int POS_MAX = DATA_W + HAM_W;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [CHK_W-1:0]  chk_t;
  typedef logic [BYTES-1:0]  bmask_t;

  // XOR of the code positions of all set data bits (powers of two hold check bits)
  function automatic logic [HAM_W-1:0] ham_fold(input word_t d);
    logic [HAM_W-1:0] acc;
    int k;
    acc = '0;
    k = 0;
    for (int p = 1; p <= POS_MAX; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[k]) acc ^= HAM_W'(p);
        k++;
      end
    end
    return acc;
  endfunction

  function automatic chk_t secded_encode(input word_t d);
    logic [HAM_W-1:0] h;
    h = ham_fold(d);
    return {^d ^ ^h, h};
  endfunction

  function automatic word_t flip_position(input word_t d, input logic [HAM_W-1:0] pos);
    word_t r;
    int k;
    r = d;
    k = 0;
    for (int p = 1; p <= POS_MAX; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (HAM_W'(p) == pos) r[k] = ~r[k];
        k++;
      end
    end
    return r;
  endfunction

  function automatic bmask_t byte_parity(input word_t d);
    bmask_t p;
    for (int b = 0; b < BYTES; b++) p[b] = ^d[8*b +: 8];
    return p;
  endfunction
endpackage

// File: rtl/lecc_store.sv
module lecc_store
  import lecc_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int ADDR_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  bmask_t            wr_bytes,
  input  word_t             wr_data,
  input  bmask_t            wr_par,
  input  logic              wr_chk_en,
  input  chk_t              wr_chk,
  input  logic              wr_flag_en,
  input  logic              wr_flag,
  input  logic [ADDR_W-1:0] ha_addr,
  output word_t             ha_data,
  output chk_t              ha_chk,
  output bmask_t            ha_par,
  output logic              ha_flag,
  input  logic [ADDR_W-1:0] sa_addr,
  output word_t             sa_data,
  output logic              sa_flag
);
  word_t            data_q [LINES];
  chk_t             chk_q  [LINES];
  bmask_t           par_q  [LINES];
  logic [LINES-1:0] flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        data_q[i] <= '0;
        chk_q[i]  <= '0;
        par_q[i]  <= '0;
      end
      flag_q <= '1;
    end else if (wr_en) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wr_bytes[b]) begin
          data_q[wr_addr][8*b +: 8] <= wr_data[8*b +: 8];
          par_q[wr_addr][b]         <= wr_par[b];
        end
      end
      if (wr_chk_en)  chk_q[wr_addr]  <= wr_chk;
      if (wr_flag_en) flag_q[wr_addr] <= wr_flag;
    end
  end

  assign ha_data = data_q[ha_addr];
  assign ha_chk  = chk_q[ha_addr];
  assign ha_par  = par_q[ha_addr];
  assign ha_flag = flag_q[ha_addr];
  assign sa_data = data_q[sa_addr];
  assign sa_flag = flag_q[sa_addr];

  // R3: a flag-clearing write leaves the line in parity mode
  a_r3_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_flag_en && !wr_flag) |=> !flag_q[$past(wr_addr)]);
  // R8: a check-field rebuild leaves the flag set
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_chk_en && wr_flag_en && wr_flag) |=> flag_q[$past(wr_addr)]);
endmodule

// File: rtl/lecc_check.sv
module lecc_check
  import lecc_pkg::*;
(
  input  word_t  in_data,
  input  chk_t   in_chk,
  input  bmask_t in_par,
  input  logic   in_flag,
  output word_t  out_data,
  output logic   out_corrected,
  output logic   out_uncorrectable,
  output logic   out_parity_err
);
  logic [HAM_W-1:0] syn;
  logic             ov;
  bmask_t           par_now;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign par_now[b] = ^in_data[8*b +: 8];
  end

  assign syn = ham_fold(in_data) ^ in_chk[HAM_W-1:0];
  assign ov  = ^in_data ^ ^in_chk;

  always_comb begin
    out_data          = in_data;
    out_corrected     = 1'b0;
    out_uncorrectable = 1'b0;
    out_parity_err    = 1'b0;
    if (in_flag) begin
      if (ov) begin
        if ((syn & (syn - 1'b1)) == '0) begin
          out_corrected = 1'b1;            // overall or check bit hit, data intact
        end else if (int'(syn) > POS_MAX) begin
          out_uncorrectable = 1'b1;
        end else begin
          out_data      = flip_position(in_data, syn);
          out_corrected = 1'b1;
        end
      end else if (syn != '0) begin
        out_uncorrectable = 1'b1;
      end
    end else begin
      out_parity_err = |(par_now ^ in_par);
    end
  end
endmodule

// File: rtl/lecc_scrub.sv
module lecc_scrub #(
  parameter int LINES  = 16,
  parameter int ADDR_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot,
  input  logic              line_flag,
  output logic [ADDR_W-1:0] ptr,
  output logic              fix
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LINES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (slot) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  assign fix = slot && !line_flag;

  // R10: pointer moves only in idle slots and wraps at the last line
  a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !slot |=> $stable(ptr));
  a_r10_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && ptr == LAST) |=> ptr == '0);
  a_r10_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);
endmodule

// File: rtl/lazy_ecc_ctrl.sv
module lazy_ecc_ctrl
  import lecc_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int ADDR_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTES-1:0]  req_mask,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] fault_flip,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_full_check,
  output logic              rsp_corrected,
  output logic              rsp_uncorrectable,
  output logic              rsp_parity_err
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CHECK} state_t;
  state_t state;

  logic [ADDR_W-1:0] addr_q;
  logic              whole_q;
  word_t             ld_data;
  chk_t              ld_chk;
  bmask_t            ld_par;
  logic              ld_flag;

  word_t  ha_data, sa_data;
  chk_t   ha_chk;
  bmask_t ha_par;
  logic   ha_flag, sa_flag;

  logic              wr_en, wr_chk_en, wr_flag_en, wr_flag;
  logic [ADDR_W-1:0] wr_addr;
  bmask_t            wr_bytes, wr_par;
  word_t             wr_data;
  chk_t              wr_chk;

  word_t  ck_data;
  logic   ck_corr, ck_unc, ck_perr;
  logic   scrub_slot, scrub_fix, repair;
  logic   [ADDR_W-1:0] scrub_ptr;
  logic   accept, host_wr;

  assign req_ready  = (state == S_IDLE);
  assign accept     = req_valid && req_ready;
  assign host_wr    = accept && req_write && (req_mask != '0);
  assign scrub_slot = (state == S_IDLE) && !req_valid;
  assign repair     = (state == S_CHECK) && whole_q && !ld_flag && !ck_perr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      whole_q <= 1'b0;
      ld_data <= '0;
      ld_chk  <= '0;
      ld_par  <= '0;
      ld_flag <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept && !req_write) begin
          addr_q  <= req_addr;
          whole_q <= &req_mask;
          state   <= S_FETCH;
        end
        S_FETCH: begin
          ld_data <= ha_data;
          ld_chk  <= ha_chk;
          ld_par  <= ha_par;
          ld_flag <= ha_flag;
          state   <= S_CHECK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid         <= 1'b0;
      rsp_data          <= '0;
      rsp_full_check    <= 1'b0;
      rsp_corrected     <= 1'b0;
      rsp_uncorrectable <= 1'b0;
      rsp_parity_err    <= 1'b0;
    end else begin
      rsp_valid <= (state == S_CHECK);
      if (state == S_CHECK) begin
        rsp_data          <= ck_data;
        rsp_full_check    <= ld_flag;
        rsp_corrected     <= ck_corr;
        rsp_uncorrectable <= ck_unc;
        rsp_parity_err    <= ck_perr;
      end
    end
  end

  // single write port: read repair, then host write, then scrubber
  always_comb begin
    wr_en      = 1'b0;
    wr_addr    = req_addr;
    wr_bytes   = '0;
    wr_data    = req_wdata ^ fault_flip;
    wr_par     = byte_parity(req_wdata);
    wr_chk_en  = 1'b0;
    wr_chk     = secded_encode(req_wdata);
    wr_flag_en = 1'b0;
    wr_flag    = 1'b0;
    if (repair) begin
      wr_en      = 1'b1;
      wr_addr    = addr_q;
      wr_chk_en  = 1'b1;
      wr_chk     = secded_encode(ld_data);
      wr_flag_en = 1'b1;
      wr_flag    = 1'b1;
    end else if (host_wr) begin
      wr_en      = 1'b1;
      wr_bytes   = req_mask;
      wr_chk_en  = &req_mask;
      wr_flag_en = 1'b1;
      wr_flag    = &req_mask;
    end else if (scrub_fix) begin
      wr_en      = 1'b1;
      wr_addr    = scrub_ptr;
      wr_chk_en  = 1'b1;
      wr_chk     = secded_encode(sa_data);
      wr_flag_en = 1'b1;
      wr_flag    = 1'b1;
    end
  end

  lecc_store #(.LINES(LINES), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_bytes(wr_bytes), .wr_data(wr_data),
    .wr_par(wr_par), .wr_chk_en(wr_chk_en), .wr_chk(wr_chk),
    .wr_flag_en(wr_flag_en), .wr_flag(wr_flag),
    .ha_addr(addr_q), .ha_data(ha_data), .ha_chk(ha_chk), .ha_par(ha_par), .ha_flag(ha_flag),
    .sa_addr(scrub_ptr), .sa_data(sa_data), .sa_flag(sa_flag)
  );

  lecc_check u_check (
    .in_data(ld_data), .in_chk(ld_chk), .in_par(ld_par), .in_flag(ld_flag),
    .out_data(ck_data), .out_corrected(ck_corr),
    .out_uncorrectable(ck_unc), .out_parity_err(ck_perr)
  );

  lecc_scrub #(.LINES(LINES), .ADDR_W(ADDR_W)) u_scrub (
    .clk(clk), .rst_n(rst_n), .slot(scrub_slot), .line_flag(sa_flag),
    .ptr(scrub_ptr), .fix(scrub_fix)
  );

  // R11: fixed read latency and one operation in flight
  a_r11_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |-> ##3 rsp_valid);
  a_r11_busy_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |=> !req_ready);
  a_r11_write_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> req_ready);
  // R10: host requests take priority over the scrubber
  a_r10_host_priority: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !scrub_fix);
  // R7: parity mode never reports a correction
  a_r7_parity_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_parity_err) |-> (!rsp_corrected && !rsp_uncorrectable && !rsp_full_check));
  // R5 / R6: correction and uncorrectable are exclusive
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_corrected && rsp_uncorrectable));
  // R9: no rebuild after a parity error
  a_r9_no_repair_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHECK && ck_perr) |-> !wr_chk_en);
endmodule

// File: tb/lazy_ecc_ctrl_bench.sv
module lazy_ecc_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 16;
  localparam int AW = $clog2(LINES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_mask = '0;
  logic [63:0] req_wdata = '0, fault_flip = '0;
  logic req_ready, rsp_valid, rsp_full_check, rsp_corrected, rsp_uncorrectable, rsp_parity_err;
  logic [63:0] rsp_data;

  int n_checks = 0, n_err = 0;
  bit done = 1'b0;
  logic [63:0] r_data;
  logic r_full, r_corr, r_unc, r_perr;

  always #(CLK_PERIOD/2) clk = ~clk;

  lazy_ecc_ctrl #(.LINES(LINES)) u_lazy_ecc_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_mask(req_mask),
    .req_wdata(req_wdata), .fault_flip(fault_flip), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_full_check(rsp_full_check), .rsp_corrected(rsp_corrected),
    .rsp_uncorrectable(rsp_uncorrectable), .rsp_parity_err(rsp_parity_err)
  );

  function automatic logic [63:0] pat(input int n);
    return 64'h9E37_79B9_7F4A_7C15 * 64'(n + 1) ^ 64'(n);
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] old_w, new_w, input logic [7:0] m);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = m[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // leaves req_valid high so the next operation follows without an idle cycle
  task automatic do_write(input int a, input logic [63:0] d, input logic [7:0] m, input logic [63:0] f);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a);
    req_mask = m; req_wdata = d; fault_flip = f;
    @(negedge clk);
    check(req_ready == 1'b1, "R3 write keeps ready", 64'(req_ready), 64'd1);
  endtask

  task automatic do_read(input int a, input logic [7:0] m);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a); req_mask = m; fault_flip = '0;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready && !rsp_valid, "R11 busy after accept", {62'd0, req_ready, rsp_valid}, 64'd0);
    @(negedge clk);
    check(!rsp_valid && !req_ready, "R11 no early response", {62'd0, req_ready, rsp_valid}, 64'd0);
    @(negedge clk);
    check(rsp_valid && req_ready, "R11 response after two edges", {62'd0, req_ready, rsp_valid}, 64'd3);
    r_data = rsp_data; r_full = rsp_full_check; r_corr = rsp_corrected;
    r_unc = rsp_uncorrectable; r_perr = rsp_parity_err;
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] flags();
    return {60'd0, r_full, r_corr, r_unc, r_perr};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid, "R1 reset outputs", {62'd0, req_ready, rsp_valid}, 64'd2);

    // R1: all lines zero, full check, no errors
    for (int l = 0; l < LINES; l++) begin
      do_read(l, 8'hFF);
      check(r_data == 64'd0, "R1 reset data", r_data, 64'd0);
      check(flags() == 64'h8, "R1 reset flags", flags(), 64'h8);
    end

    // R2: whole-line writes and clean reads
    for (int l = 0; l < LINES; l++) do_write(l, pat(l), 8'hFF, '0);
    for (int l = 0; l < LINES; l++) begin
      do_read(l, 8'hFF);
      check(r_data == pat(l), "R2 data", r_data, pat(l));
      check(flags() == 64'h8, "R2 flags", flags(), 64'h8);
    end

    // R3: byte merge and flag clear (partial read does not repair)
    for (int b = 0; b < 8; b++) begin
      logic [7:0] m;
      m = (8'h01 << b) | 8'h10;
      do_write(b, pat(100 + b), 8'hFF, '0);
      do_write(b, pat(200 + b), m, '0);
      do_read(b, 8'h01);
      check(r_data == merge(pat(100 + b), pat(200 + b), m), "R3 merged data",
            r_data, merge(pat(100 + b), pat(200 + b), m));
      check(flags() == 64'h0, "R3 parity mode", flags(), 64'h0);
    end

    // R4: zero mask write has no effect
    do_write(9, pat(300), 8'hFF, '0);
    do_write(9, pat(301), 8'h00, '1);
    do_read(9, 8'h01);
    check(r_data == pat(300), "R4 data kept", r_data, pat(300));
    check(flags() == 64'h8, "R4 flag kept", flags(), 64'h8);

    // R5: every single data bit corrected
    for (int bit_i = 0; bit_i < 64; bit_i++) begin
      do_write(bit_i % LINES, pat(400 + bit_i), 8'hFF, 64'd1 << bit_i);
      do_read(bit_i % LINES, 8'hFF);
      check(r_data == pat(400 + bit_i), "R5 corrected data", r_data, pat(400 + bit_i));
      check(flags() == 64'hC, "R5 flags", flags(), 64'hC);
    end

    // R6: double flips detected
    for (int bit_i = 0; bit_i < 64; bit_i++) begin
      do_write(bit_i % LINES, pat(500 + bit_i), 8'hFF,
               (64'd1 << bit_i) | (64'd1 << ((bit_i + 9) % 64)));
      do_read(bit_i % LINES, 8'hFF);
      check(flags() == 64'hA, "R6 flags", flags(), 64'hA);
    end

    // R7 / R9: parity error in parity mode, no repair afterwards
    for (int b = 0; b < 8; b++) begin
      logic [63:0] f, e;
      f = 64'd1 << (8 * b + (7 - b));
      e = merge(pat(600 + b), pat(700 + b), 8'h01 << b) ^ f;
      do_write(b, pat(600 + b), 8'hFF, '0);
      do_write(b, pat(700 + b), 8'h01 << b, f);
      do_read(b, 8'hFF);
      check(r_data == e, "R7 raw data", r_data, e);
      check(flags() == 64'h1, "R7 flags", flags(), 64'h1);
      do_read(b, 8'hFF);
      check(flags() == 64'h1, "R9 flag unchanged after error", flags(), 64'h1);
    end

    // R8: clean whole-line read rebuilds check field
    do_write(10, pat(801), 8'hFF, '0);
    do_write(10, pat(800), 8'h3C, '0);
    do_read(10, 8'hFF);
    check(r_data == merge(pat(801), pat(800), 8'h3C), "R8 data", r_data, merge(pat(801), pat(800), 8'h3C));
    check(flags() == 64'h0, "R8 first read parity mode", flags(), 64'h0);
    do_read(10, 8'h01);
    check(flags() == 64'h8, "R8 repaired", flags(), 64'h8);
    check(r_data == merge(pat(801), pat(800), 8'h3C), "R8 data kept", r_data, merge(pat(801), pat(800), 8'h3C));

    // R10: scrubber waits while requests keep coming, then restores every line
    for (int l = 0; l < LINES; l++) do_write(l, pat(950 + l), 8'hFF, '0);
    for (int l = 0; l < LINES; l++) do_write(l, pat(900 + l), 8'h81, '0);
    for (int l = 0; l < LINES; l++) begin
      do_read(l, 8'h7E);
      check(flags() == 64'h0, "R10 no scrub under load", flags(), 64'h0);
    end
    idle(LINES + 1);
    for (int l = 0; l < LINES; l++) begin
      do_read(l, 8'h7E);
      check(flags() == 64'h8, "R10 scrubbed", flags(), 64'h8);
      check(r_data == merge(pat(950 + l), pat(900 + l), 8'h81), "R10 data",
            r_data, merge(pat(950 + l), pat(900 + l), 8'h81));
    end

    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule